// File: doc/BRIEF.md
# Frame-Synchronised Serial Word Receiver with Programmable Data Lag

This block turns a serial bit stream into parallel words, one word per frame. All timing comes from a bit clock and a frame-sync input. Both the frame sync and the serial data are sampled on the falling edge of the bit clock. A frame begins on the first falling edge at which the frame sync is seen high after it was low.

A 2-bit lag setting chooses how many bit clocks pass between that frame start and the first data bit, from zero to two.

- With zero lag, the first bit is taken on the same edge that detects the sync.
- With a lag of two, the bit that follows one period after the start is a framing bit and is thrown away.

Bits arrive most significant first. Once the last bit of the word is in, the word appears on the parallel output together with a one-cycle valid strobe, and it stays there until the next word completes. A new frame start that arrives before the current word is complete raises a one-cycle error pulse, and reception restarts from the new frame. Between frames the data line has no effect on the outputs.

Top module: `fs_delay_rx`

## Requirements
- R1: While reset is high at a falling edge of the bit clock, `word_out` is cleared to zero and `word_vld` and `frame_err` are low; they stay that way after reset until a word completes.
- R2: A frame starts only on a falling edge where `fsync` is high and was low at the previous falling edge. A sync held high for several periods starts exactly one frame.
- R3: With `lag_sel` = 2'b00, the first data bit is the `sdata` value sampled on the frame-start edge.
- R4: With `lag_sel` = 2'b01, the first data bit is sampled one falling edge after the frame-start edge.
- R5: With `lag_sel` = 2'b10, the bit sampled one edge after the frame start is discarded, and the first data bit is sampled two edges after the frame start.
- R6: The reserved code `lag_sel` = 2'b11 behaves exactly like 2'b01.
- R7: The first data bit received lands in `word_out[WORD_W-1]`, and each later bit lands one position lower.
- R8: `word_vld` is high for exactly one bit-clock period, starting at the falling edge that samples the last data bit. `word_out` changes only at that edge and otherwise holds its value.
- R9: `lag_sel` is used only at the frame-start edge. Changing it later in the frame does not alter the word received.
- R10: A frame start while a word is incomplete makes `frame_err` high for one period from that edge. No `word_vld` is given for the aborted word, and the new frame is received with the lag selected at its own start.
- R11: A frame start on the same edge that samples the last bit of the current word completes that word normally, with no error, and also starts the new frame.
- R12: Between frames, `sdata` does not affect `word_out`, `word_vld` or `frame_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock; all sampling and state changes occur on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, active high |
| sdata | input | 1 | Serial data, most significant bit first |
| lag_sel | input | 2 | Data lag code: 00 none, 01 one bit, 10 two bits, 11 treated as 01 |
| word_out | output | WORD_W | Last completed word |
| word_vld | output | 1 | One-period strobe when a new word is on `word_out` |
| frame_err | output | 1 | One-period pulse when a frame restarts an incomplete word |

## Verification
Every 8-bit value is received under each of the four lag codes. This separates an off-by-one lag, a wrong bit order and a mishandled reserved code, because each fault shifts or reverses a different set of words.

- The framing slot is driven with the inverse of the word's lowest bit and the idle slots with pseudo-random noise, so any sampling of the discarded or idle bits corrupts some words.
- The lag code is flipped right after each frame start, which shows whether the block latches the lag at the start or reads it later.

Dedicated sequences cover a sync held high for three periods, a restart in the middle of a word, and back-to-back frames whose sync coincides with the last bit. These separate edge detection from level detection, and an abort from a normal completion.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;

    // Receiver sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SKIP  = 2'd1,
        ST_SHIFT = 2'd2
    } rx_state_e;

    // Effective data lag after decoding the 2-bit setting
    typedef enum logic [1:0] {
        LAG_0 = 2'd0,
        LAG_1 = 2'd1,
        LAG_2 = 2'd2
    } lag_e;

    // Per-edge events passed from the sequencer to the capture stage
    typedef struct packed {
        logic done;   // this edge samples the last bit of a word
        logic abort;  // a frame start cut an incomplete word short
    } rx_evt_t;

    // The reserved code falls back to a one-bit lag
    function automatic lag_e decode_lag(input logic [1:0] code);
        lag_e r;
        case (code)
            2'b00:   r = LAG_0;
            2'b10:   r = LAG_2;
            default: r = LAG_1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fsrx_start_det.sv
module fsrx_start_det (
    input  logic bit_clk,
    input  logic rst,
    input  logic fsync,
    output logic start
);
    logic fs_q;

    always_ff @(negedge bit_clk) begin
        if (rst) fs_q <= 1'b0;
        else     fs_q <= fsync;
    end

    // First sampled cycle with sync active
    assign start = fsync & ~fs_q & ~rst;

    // R2: a start can never repeat on consecutive edges
    p_start_once_r2: assert property (@(negedge bit_clk) disable iff (rst)
        start |=> !start);

endmodule

// File: rtl/fsrx_ctrl.sv
module fsrx_ctrl
    import fsrx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic       bit_clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] lag_sel,
    output rx_evt_t    evt
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LESS_CNT = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    rx_state_e        st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             last_bit;
    lag_e             lag_now;

    assign lag_now  = decode_lag(lag_sel);
    assign last_bit = (st == ST_SHIFT) && (cnt == ONE_CNT);

    always_comb begin
        st_n      = st;
        cnt_n     = cnt;
        evt       = '0;
        case (st)
            ST_SKIP: begin
                // framing bit sampled here and dropped
                st_n  = ST_SHIFT;
                cnt_n = FULL_CNT;
            end
            ST_SHIFT: begin
                cnt_n = cnt - ONE_CNT;
                if (last_bit) begin
                    st_n     = ST_IDLE;
                    evt.done = 1'b1;
                end
            end
            default: ;
        endcase
        if (start) begin
            evt.abort = (st != ST_IDLE) && !last_bit;
            case (lag_now)
                LAG_0: begin
                    // this edge already carries the first bit
                    st_n  = ST_SHIFT;
                    cnt_n = LESS_CNT;
                end
                LAG_2: begin
                    st_n  = ST_SKIP;
                    cnt_n = '0;
                end
                default: begin
                    st_n  = ST_SHIFT;
                    cnt_n = FULL_CNT;
                end
            endcase
        end
    end

    always_ff @(negedge bit_clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // R3: zero lag counts the start edge as the first bit
    p_zero_lag_r3: assert property (@(negedge bit_clk) disable iff (rst)
        (start && lag_sel == 2'b00) |=> (st == ST_SHIFT && cnt == LESS_CNT));
    // R5: the framing slot is followed by a full word of shifting
    p_skip_then_shift_r5: assert property (@(negedge bit_clk) disable iff (rst)
        (st == ST_SKIP && !start) |=> (st == ST_SHIFT && cnt == FULL_CNT));
    // R6: the reserved code starts like a one-bit lag
    p_reserved_code_r6: assert property (@(negedge bit_clk) disable iff (rst)
        (start && lag_sel == 2'b11) |=> (st == ST_SHIFT && cnt == FULL_CNT));
    // R10: an abort only happens while a word is in progress
    p_abort_busy_r10: assert property (@(negedge bit_clk) disable iff (rst)
        evt.abort |-> (start && st != ST_IDLE));

endmodule

// File: rtl/fsrx_capture.sv
module fsrx_capture
    import fsrx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              bit_clk,
    input  logic              rst,
    input  logic              sdata,
    input  rx_evt_t           evt,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              frame_err
);
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] word_n;

    // Shift register of the most recent samples, MSB first
    assign word_n = {sh[WORD_W-2:0], sdata};

    always_ff @(negedge bit_clk) begin
        if (rst) begin
            sh        <= '0;
            word_out  <= '0;
            word_vld  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            sh        <= word_n;
            word_vld  <= evt.done;
            frame_err <= evt.abort;
            if (evt.done) word_out <= word_n;
        end
    end

    // R8: one-period strobe
    p_vld_pulse_r8: assert property (@(negedge bit_clk) disable iff (rst)
        word_vld |=> !word_vld);
    // R8: output word holds unless a strobe accompanies it
    p_word_hold_r8: assert property (@(negedge bit_clk) disable iff (rst)
        !word_vld |-> $stable(word_out));
    // R10: an aborted word never raises valid
    p_err_no_vld_r10: assert property (@(negedge bit_clk) disable iff (rst)
        frame_err |-> !word_vld);
    // R10: error is a single-period pulse
    p_err_pulse_r10: assert property (@(negedge bit_clk) disable iff (rst)
        frame_err |=> !frame_err);

endmodule

// File: rtl/fs_delay_rx.sv
module fs_delay_rx
    import fsrx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              bit_clk,
    input  logic              rst,
    input  logic              fsync,
    input  logic              sdata,
    input  logic [1:0]        lag_sel,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              frame_err
);
    logic    start;
    rx_evt_t evt;

    fsrx_start_det u_start (
        .bit_clk (bit_clk),
        .rst     (rst),
        .fsync   (fsync),
        .start   (start)
    );

    fsrx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .bit_clk (bit_clk),
        .rst     (rst),
        .start   (start),
        .lag_sel (lag_sel),
        .evt     (evt)
    );

    fsrx_capture #(.WORD_W(WORD_W)) u_cap (
        .bit_clk   (bit_clk),
        .rst       (rst),
        .sdata     (sdata),
        .evt       (evt),
        .word_out  (word_out),
        .word_vld  (word_vld),
        .frame_err (frame_err)
    );

endmodule

// File: tb/fs_delay_rx_bench.sv
module fs_delay_rx_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fsync = 1'b0;
    logic         sdata = 1'b0;
    logic [1:0]   lag = 2'b01;
    logic [W-1:0] word_out;
    logic         vld, err;

    logic [W-1:0] obs_w;
    logic         obs_v, obs_e;
    logic [15:0]  lfsr = 16'hACE1;
    logic [W-1:0] exp_word = '0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fs_delay_rx #(.WORD_W(W)) u_fs_delay_rx (
        .bit_clk (clk), .rst (rst), .fsync (fsync), .sdata (sdata),
        .lag_sel (lag), .word_out (word_out), .word_vld (vld), .frame_err (err)
    );

    task automatic noise(output logic b);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        b = lfsr[0];
    endtask

    // Samples outputs produced by the previous falling edge, then drives the next slot
    task automatic step(input logic fs, input logic d);
        @(posedge clk);
        #1;
        obs_v = vld; obs_w = word_out; obs_e = err;
        fsync = fs; sdata = d;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic [W-1:0] w, input logic [1:0] code, input logic frm, input int gap);
        int    eff;
        string tg;
        logic  d;
        eff = (code == 2'b00) ? 0 : (code == 2'b10) ? 2 : 1;
        tg  = (code == 2'b00) ? "R3" : (code == 2'b01) ? "R4" : (code == 2'b10) ? "R5" : "R6";
        for (int s = 0; s < eff + W; s++) begin
            if (s >= eff)                d = w[W-1-(s-eff)];
            else if (eff == 2 && s == 1) d = frm;
            else                         noise(d);
            step(s == 0, d);
            lag = (s == 0) ? code : ~code;   // R9: later changes ignored
            if (s >= 1) begin
                chk(!obs_v && !obs_e, "R8 no early strobe", {obs_v, obs_e}, 0);
                chk(obs_w == exp_word, "R8 hold during frame", obs_w, exp_word);
            end
        end
        noise(d); step(1'b0, d); lag = code;
        chk(obs_v, {tg, " valid"}, obs_v, 1);
        chk(obs_w == w, {tg, " R7 R9 word"}, obs_w, w);
        chk(!obs_e, {tg, " no error"}, obs_e, 0);
        exp_word = w;
        noise(d); step(1'b0, d);
        chk(!obs_v && obs_w == w, "R8 single pulse and hold", {obs_v, obs_w}, {1'b0, w});
        for (int g = 0; g < gap; g++) begin
            noise(d); step(1'b0, d);
            chk(!obs_v && !obs_e && obs_w == w, "R12 idle data ignored", {obs_v, obs_e, obs_w}, {2'b00, w});
        end
    endtask

    initial begin
        logic [W-1:0] a, b;
        logic d;
        repeat (3) @(posedge clk);
        #1;
        obs_v = vld; obs_w = word_out; obs_e = err;
        chk(obs_w == 0 && !obs_v && !obs_e, "R1 reset state", {obs_v, obs_e, obs_w}, 0);
        rst = 1'b0;
        step(1'b0, 1'b1); step(1'b0, 1'b1);
        chk(obs_w == 0 && !obs_v && !obs_e, "R1 after reset", {obs_v, obs_e, obs_w}, 0);

        // R2: sync held for three periods, one-bit lag
        a = 8'hA5; lag = 2'b01;
        for (int s = 0; s <= W; s++) begin
            step(s < 3, (s >= 1) ? a[W-s] : 1'b0);
            if (s >= 1) chk(!obs_v && !obs_e, "R2 no restart", {obs_v, obs_e}, 0);
        end
        step(1'b0, 1'b0);
        chk(obs_v && obs_w == a && !obs_e, "R2 held sync word", {obs_v, obs_e, obs_w}, {2'b10, a});
        exp_word = a;
        step(1'b0, 1'b0);

        // R10: restart in the middle of a word, new frame uses two-bit lag
        a = 8'h3C; b = 8'hC3;
        for (int s = 0; s <= 13; s++) begin
            if (s >= 1 && s <= 3) d = a[W-s];
            else if (s == 5)      d = 1'b1;
            else if (s >= 6)      d = b[W-1-(s-6)];
            else                  d = 1'b0;
            step(s == 0 || s == 4, d);
            lag = (s == 4) ? 2'b10 : 2'b01;
            if (s >= 1) begin
                chk(obs_e == (s == 5), "R10 error pulse", obs_e, (s == 5));
                chk(!obs_v, "R10 no strobe for aborted word", obs_v, 0);
            end
        end
        step(1'b0, 1'b0);
        chk(obs_v && obs_w == b, "R10 restarted word", {obs_v, obs_w}, {1'b1, b});
        exp_word = b;
        step(1'b0, 1'b0);

        // R11: next sync on the last bit of the current word
        a = 8'h5A; b = 8'h96; lag = 2'b01;
        for (int s = 0; s <= 16; s++) begin
            if (s >= 1 && s <= 8) d = a[8-s];
            else if (s >= 9)      d = b[16-s];
            else                  d = 1'b0;
            step(s == 0 || s == 8, d);
            if (s == 9) chk(obs_v && obs_w == a && !obs_e, "R11 word at overlap", {obs_v, obs_e, obs_w}, {2'b10, a});
            else if (s >= 1) chk(!obs_v && !obs_e, "R11 quiet", {obs_v, obs_e}, 0);
        end
        step(1'b0, 1'b0);
        chk(obs_v && obs_w == b && !obs_e, "R11 second word", {obs_v, obs_e, obs_w}, {2'b10, b});
        exp_word = b;
        step(1'b0, 1'b0);

        // Exhaustive sweep: all words under all four lag codes
        for (int c = 0; c < 4; c++)
            for (int v = 0; v < 256; v++)
                send_frame(W'(v), 2'(c), ~v[0], v % 3);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule